// File: doc/BRIEF.md
# Phase-Sampled Timer Count Synchronizer

This block drives an 8-bit up-counting timer. The count comes from one of two sources: the core's own instruction cycle, or an asynchronous signal on an external pin. The pin may carry a raw clock or one that has already been divided before it arrives. Every instruction cycle spans four core clocks, called Q1 to Q4, and a free-running phase counter produces them. The external signal is sampled only on the clock edges that end Q2 and Q4. A qualifying transition between two successive samples becomes a one-clock increment request, so the timer moves a fixed, short time after the pin edge.

Software sets the count source and picks whether a rising or a falling pin edge counts. It can load the timer at any time. After a load, increments are held off for two instruction cycles. When the timer wraps from 0xFF to 0x00 it raises a sticky overflow flag, and that flag stays set until software clears it.

Top module: `tcnt_phase_sync`

## Requirements
- R1: While reset is asserted and right after it is released, `tmr_q` is 0x00 and `ovf_q` is 0. The phase counter starts at Q1 (encoding 0) and advances by one on every clock, through Q2=1, Q3=2 and Q4=3 and back to Q1.
- R2: In external mode (`src_ext`=1), each qualifying pin edge adds exactly one to the timer when the pin stays at least two clocks high and at least two clocks low, whatever the alignment to the phases.
- R3: If the pin change is already present at the clock edge that ends Q2 or Q4, the timer shows the new value after the following clock edge, two edges after the pin change. No pin sample is taken at the edges that end Q1 or Q3.
- R4: A pulse of one clock that falls entirely within a Q1 or a Q3 phase is not counted. This applies to a high pulse and to a low gap alike.
- R5: With `edge_fall`=1, only high-to-low pin transitions count and rising ones are ignored. With `edge_fall`=0 the reverse holds.
- R6: In internal mode (`src_ext`=0), the timer increments once per instruction cycle, on the clock edge that ends Q4. The pin has no effect in this mode.
- R7: An increment from 0xFF gives 0x00 and sets `ovf_q`. The flag stays set through later increments until `ovf_clr` is pulsed. If a wrap and a clear fall on the same edge, the wrap wins.
- R8: A write (`wr_en`) loads `wr_data` on that edge and takes priority over any increment on the same edge. Increment requests on the next eight clock edges (two instruction cycles) are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core (oscillator) clock; four clocks form one instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external count signal |
| src_ext | input | 1 | 1 = count synchronized pin edges, 0 = count instruction cycles |
| edge_fall | input | 1 | 1 = falling pin edges count, 0 = rising edges count |
| wr_en | input | 1 | Software write strobe for the timer |
| wr_data | input | 8 | Value loaded into the timer on a write |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| tmr_q | output | 8 | Current timer value |
| ovf_q | output | 1 | Sticky overflow flag |

## Verification
The hardest situation to reach is a pulse narrower than the minimum width that lands exactly between two sampling edges. The cases where such a pulse is correctly missed cannot be told apart from those where it is wrongly caught unless the stimulus knows the phase. The bench therefore counts clocks from reset release, since the phase is a pure function of that count. It waits for a chosen phase before it moves the pin, which places one-clock glitches inside Q1 or Q3 and places edges just ahead of a Q2 sample so the exact latency can be checked. The write-inhibit window is set up the same way, with the load aligned to a Q4 edge so that the two blocked internal ticks and the first allowed one fall on known cycles.

// File: rtl/tps_pkg.sv
package tps_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  localparam int PHASES_PER_INSTR = 4;

  // Phase order of the instruction cycle.
  function automatic phase_e phase_after(phase_e p);
    unique case (p)
      PH_Q1:   return PH_Q2;
      PH_Q2:   return PH_Q3;
      PH_Q3:   return PH_Q4;
      default: return PH_Q1;
    endcase
  endfunction

  // The pin is looked at only at the close of Q2 and Q4.
  function automatic logic takes_sample(phase_e p);
    return (p == PH_Q2) || (p == PH_Q4);
  endfunction

  // Transition between two successive samples, with the chosen polarity.
  function automatic logic qualifies(logic older, logic newer, logic falling);
    return falling ? (older & ~newer) : (~older & newer);
  endfunction

endpackage

// File: rtl/tps_phase_gen.sv
module tps_phase_gen
  import tps_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase,
  output logic   instr_tick
);

  phase_e ph_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_r <= PH_Q1;
    else        ph_r <= phase_after(ph_r);
  end

  assign phase      = ph_r;
  assign instr_tick = (ph_r == PH_Q4);

endmodule

// File: rtl/tps_edge_sampler.sv
module tps_edge_sampler
  import tps_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   pin,
  input  logic   edge_fall,
  output logic   ext_evt
);

  logic held_lvl;   // raw pin level taken at the last sampling edge
  logic evt_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_lvl <= 1'b0;
      evt_r    <= 1'b0;
    end else if (takes_sample(phase)) begin
      held_lvl <= pin;
      evt_r    <= qualifies(held_lvl, pin, edge_fall);
    end else begin
      evt_r    <= 1'b0;
    end
  end

  assign ext_evt = evt_r;

endmodule

// File: rtl/tps_timer_reg.sv
module tps_timer_reg #(
  parameter int W        = 8,
  parameter int HOLD_CLK = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_req,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         ovf_clr,
  output logic [W-1:0] cnt,
  output logic         ovf,
  output logic         inc_fire,
  output logic         wrap_evt
);

  localparam int HW = $clog2(HOLD_CLK + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(HOLD_CLK);

  logic [W-1:0]  cnt_r;
  logic [HW-1:0] hold_r;
  logic          ovf_r;

  function automatic logic [W-1:0] bump(logic [W-1:0] v);
    return v + W'(1);
  endfunction

  assign inc_fire = inc_req && !wr_en && (hold_r == '0);
  assign wrap_evt = inc_fire && (cnt_r == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r  <= '0;
      hold_r <= '0;
    end else if (wr_en) begin
      cnt_r  <= wr_data;
      hold_r <= HOLD_INIT;
    end else begin
      if (hold_r != '0) hold_r <= hold_r - HW'(1);
      if (inc_fire)     cnt_r  <= bump(cnt_r);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_r <= 1'b0;
    else if (wrap_evt) ovf_r <= 1'b1;
    else if (ovf_clr)  ovf_r <= 1'b0;
  end

  assign cnt = cnt_r;
  assign ovf = ovf_r;

endmodule

// File: rtl/tcnt_phase_sync.sv
module tcnt_phase_sync
  import tps_pkg::*;
#(
  parameter int TMR_W      = 8,
  parameter int HOLD_INSTR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic             src_ext,
  input  logic             edge_fall,
  input  logic             wr_en,
  input  logic [TMR_W-1:0] wr_data,
  input  logic             ovf_clr,
  output logic [TMR_W-1:0] tmr_q,
  output logic             ovf_q
);

  localparam int HOLD_CLK = HOLD_INSTR * PHASES_PER_INSTR;

  phase_e phase;
  logic   instr_tick;
  logic   ext_evt;
  logic   inc_req;
  logic   inc_fire;
  logic   wrap_evt;

  tps_phase_gen u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .instr_tick(instr_tick)
  );

  tps_edge_sampler u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .pin      (ext_pin),
    .edge_fall(edge_fall),
    .ext_evt  (ext_evt)
  );

  assign inc_req = src_ext ? ext_evt : instr_tick;

  tps_timer_reg #(
    .W       (TMR_W),
    .HOLD_CLK(HOLD_CLK)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_req (inc_req),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ovf_clr (ovf_clr),
    .cnt     (tmr_q),
    .ovf     (ovf_q),
    .inc_fire(inc_fire),
    .wrap_evt(wrap_evt)
  );

endmodule

// File: rtl/tcnt_phase_sync_chk.sv
module tcnt_phase_sync_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   phase,
  input logic         ext_evt,
  input logic         inc_fire,
  input logic         wrap_evt,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         ovf_clr,
  input logic [W-1:0] tmr_q,
  input logic         ovf_q
);

  // R3: a pin event is produced only by a Q2 or Q4 sampling edge
  assert_evt_on_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |-> ($past(phase) == 2'd1 || $past(phase) == 2'd3));

  // R3: the increment request lasts one clock
  assert_evt_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> !ext_evt);

  // R2: without a write the timer only ever steps by one
  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && tmr_q != $past(tmr_q)) |-> (tmr_q == W'($past(tmr_q) + 1)));

  // R7: flag survives until cleared
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovf_q) && !$past(ovf_clr)) |-> ovf_q);

  // R7: a wrap always leaves the flag set
  assert_wrap_sets_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (ovf_q && tmr_q == '0));

  // R8: a write lands and wins over any increment
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tmr_q == $past(wr_data)));

  // R8: no increment fires on the edge right after a write
  assert_hold_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> !inc_fire);

endmodule

bind tcnt_phase_sync tcnt_phase_sync_chk #(.W(TMR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .phase   (phase),
  .ext_evt (ext_evt),
  .inc_fire(inc_fire),
  .wrap_evt(wrap_evt),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .ovf_clr (ovf_clr),
  .tmr_q   (tmr_q),
  .ovf_q   (ovf_q)
);

// File: tb/tcnt_phase_sync_tb.sv
module tcnt_phase_sync_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_pin, src_ext, edge_fall, wr_en, ovf_clr;
  logic [7:0] wr_data;
  logic [7:0] tmr_q;
  logic       ovf_q;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 0;

  // Expected-item queues (scoreboard)
  int         due_q[$];
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;   // 50 MHz

  tcnt_phase_sync u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .src_ext(src_ext),
    .edge_fall(edge_fall), .wr_en(wr_en), .wr_data(wr_data),
    .ovf_clr(ovf_clr), .tmr_q(tmr_q), .ovf_q(ovf_q)
  );

  // Clock edges since reset release; at a negedge, cyc % 4 is the
  // phase (Q1=0..Q4=3) in force at the next rising edge.
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cyc %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic chk_now(input logic [7:0] v, input logic o, input string tag);
    chk({ovf_q, tmr_q} == {o, v}, tag, {ovf_q, tmr_q}, {o, v});
  endtask

  task automatic expect_at(input int due, input logic [7:0] v, input logic o, input string tag);
    due_q.push_back(due);
    exp_q.push_back({o, v});
    tag_q.push_back(tag);
  endtask

  // Monitor: pops due items and compares them with the outputs
  always @(negedge clk) begin
    if (rst_n) begin
      while (due_q.size() > 0 && due_q[0] <= cyc) begin
        automatic logic [8:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        void'(due_q.pop_front());
        chk({ovf_q, tmr_q} == e, t, {ovf_q, tmr_q}, e);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ph(input int p);
    @(negedge clk);
    while (cyc % 4 != p) @(negedge clk);
  endtask

  task automatic wide_pulse();
    ext_pin = 1'b1; step(3);
    ext_pin = 1'b0; step(3);
  endtask

  initial begin
    rst_n = 1'b0; ext_pin = 1'b0; src_ext = 1'b1; edge_fall = 1'b0;
    wr_en = 1'b0; wr_data = 8'h00; ovf_clr = 1'b0;
    step(3);
    chk_now(8'h00, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    step(4);
    chk_now(8'h00, 1'b0, "R1 after release");

    // R3: edge placed just before a Q2 sampling edge
    begin
      int c;
      wait_ph(1);
      c = cyc;
      ext_pin = 1'b1;
      expect_at(c + 1, 8'h01 - 8'h01, 1'b0, "R3 not yet counted");
      expect_at(c + 2, 8'h01, 1'b0, "R3 counted after two edges");
      step(4);
      ext_pin = 1'b0;
      step(4);
    end

    // R2: minimum-width pulses (2 clocks high, 2 low) at shifting alignment
    for (int i = 0; i < 5; i++) begin
      step(1 + i);
      ext_pin = 1'b1; step(2);
      ext_pin = 1'b0; step(2);
    end
    step(4);
    chk_now(8'h06, 1'b0, "R2 five 2-clock pulses");

    // R4: one-clock high pulse inside Q1 is not seen
    wait_ph(0);
    ext_pin = 1'b1; step(1);
    ext_pin = 1'b0; step(4);
    chk_now(8'h06, 1'b0, "R4 short high pulse ignored");

    // R4: one-clock low gap inside Q3 is not seen
    ext_pin = 1'b1; step(6);
    chk_now(8'h07, 1'b0, "R4 wide pulse counted");
    wait_ph(2);
    ext_pin = 1'b0; step(1);
    ext_pin = 1'b1; step(4);
    chk_now(8'h07, 1'b0, "R4 short low gap ignored");
    ext_pin = 1'b0; step(4);

    // R5: falling-edge selection
    edge_fall = 1'b1; step(4);
    ext_pin = 1'b1; step(4);
    chk_now(8'h07, 1'b0, "R5 rise ignored in falling mode");
    ext_pin = 1'b0; step(4);
    chk_now(8'h08, 1'b0, "R5 fall counted");
    edge_fall = 1'b0; step(4);

    // R6: internal source, pin toggles ignored
    begin
      int c;
      wait_ph(0);
      c = cyc;
      src_ext = 1'b0;
      expect_at(c + 3, 8'h08, 1'b0, "R6 before first Q4");
      expect_at(c + 4, 8'h09, 1'b0, "R6 first Q4 tick");
      expect_at(c + 16, 8'h0C, 1'b0, "R6 four instruction cycles");
      for (int k = 0; k < 12; k++) begin
        ext_pin = ~ext_pin; step(1);
      end
      ext_pin = 1'b0;
      step(4);
      src_ext = 1'b1;
      step(4);
    end

    // R7: wrap, sticky flag, clear
    wr_data = 8'hFE; wr_en = 1'b1; step(1);
    wr_en = 1'b0;
    chk_now(8'hFE, 1'b0, "R7 preload");
    step(10);
    wide_pulse(); wide_pulse();
    chk_now(8'h00, 1'b1, "R7 wrap sets flag");
    wide_pulse();
    chk_now(8'h01, 1'b1, "R7 flag sticky");
    ovf_clr = 1'b1; step(1);
    ovf_clr = 1'b0;
    chk_now(8'h01, 1'b0, "R7 flag cleared");

    // R8: write on a Q4 edge in internal mode, then inhibit window
    begin
      int w;
      wait_ph(3);
      w = cyc;
      src_ext = 1'b0;
      wr_data = 8'h40; wr_en = 1'b1;
      expect_at(w + 1, 8'h40, 1'b0, "R8 write wins over tick");
      expect_at(w + 12, 8'h40, 1'b0, "R8 two ticks suppressed");
      expect_at(w + 13, 8'h41, 1'b0, "R8 counting resumes");
      step(1);
      wr_en = 1'b0;
      step(14);
      src_ext = 1'b1;
      step(2);
    end

    chk(due_q.size() == 0, "scoreboard drained", due_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule